// File: doc/BRIEF.md
# Indexed Slot Memory Window Mapper

This block is the register file and address decoder of a card-slot controller. A host programs it through two byte-wide ports: an index port that selects a register and a data port that reads or writes the selected byte. Each slot owns a 64-byte register space. The space holds five memory windows and two I/O windows, and each window has start, stop and (for memory only) offset fields.

Two combinational lookup ports sit next to the host port. The memory lookup takes a 24-bit system address. It reports whether an enabled window covers the address, which slot and window won, and the translated card address. It also reports whether the access goes to attribute or common memory, and whether it is 16 bits wide. The I/O lookup takes a 16-bit port address and reports the hit, the slot, the window and the 16-bit chip-select flag. It does not translate the address. Memory is mapped in 4 KiB pages, so all memory fields are 12-bit page numbers.

Top module: `slot_window_map`

## Requirements
- R1: With `host_sel_data`=0, `host_rdata` returns the index register. The index register changes only on a write with `host_sel_data`=0, so consecutive data-port accesses reach the same register.
- R2: A data-port read returns the byte last written to the indexed register if that register is implemented. The implemented registers are 0x06, 0x07, 0x08–0x0F, and 0x10+8n to 0x15+8n for n = 0 to 4. Every other index reads 0x00, and a write to it has no effect.
- R3: After synchronous active-low reset, every register and the index read 0x00, and neither lookup port reports a hit.
- R4: Memory window n of a slot hits only while bit n of register 0x06 is set and the page (system address bits [23:12]) lies between the start field and the stop field, both bounds inclusive.
- R5: On a memory hit, `mem_card_addr` = {(page + offset field) mod 4096, system address bits [11:0]}.
- R6: Bit 6 of the offset high byte drives `mem_attr` (1 = attribute memory). Bit 7 of the start high byte drives `mem_wide` (1 = 16-bit).
- R7: When several enabled windows hit, the lowest slot wins. Within that slot, the lowest window wins.
- R8: I/O window w (0 or 1) hits while bit 6+w of register 0x06 is set and the port address lies between its 16-bit start and stop, both bounds inclusive. Start is at 0x08+4w (low byte, then high byte) and stop is at 0x0A+4w. `io_wide` is bit w of register 0x07.
- R9: Index bits [7:6] select the slot and bits [5:0] select the register. Memory window n has its start at 0x10+8n, its stop at 0x12+8n and its offset at 0x14+8n, each stored as the low byte then the high byte. A slot number at or above NUM_SLOTS (default 2) ignores writes and reads 0x00.
- R10: Each 12-bit memory field is {high byte bits [3:0], low byte}. The control bits in high-byte bits [7:4] do not change the address compare or the translation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_sel_data | input | 1 | 0 selects the index port, 1 selects the data port |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte (index or selected register) |
| mem_addr | input | 24 | System memory address to look up |
| mem_hit | output | 1 | An enabled memory window covers mem_addr |
| mem_slot | output | 2 | Winning slot |
| mem_win | output | 3 | Winning memory window |
| mem_card_addr | output | 24 | Translated card address |
| mem_attr | output | 1 | 1 = attribute memory, 0 = common memory |
| mem_wide | output | 1 | 1 = 16-bit access |
| io_addr | input | 16 | System I/O port address to look up |
| io_hit | output | 1 | An enabled I/O window covers io_addr |
| io_slot | output | 2 | Winning slot for the I/O access |
| io_win | output | 1 | Winning I/O window |
| io_wide | output | 1 | 16-bit chip-select flag of the winning window |

## Verification
The bench probes the page just inside and just outside each bound of a window. A decoder that used a strict compare would miss the start or stop page, and an off-by-one compare would claim the neighbouring page. It sets up overlapping windows across slots and within a slot. An inverted or missing priority would then return the wrong slot or window number. It drives an offset that overflows past page 4095 to catch a translation that does not wrap, and it writes control nibbles into the high bytes to expose a field that takes in bits [7:4]. It also writes to unimplemented and out-of-range indexes. A register file that stored those bytes, or that aliased slots onto each other, would then read back a value other than 0x00.

// File: rtl/slotmap_pkg.sv
// Package: shared field widths, register numbers and window record types
// for the slot window mapper. Assumes 4 KiB pages and a 24-bit system bus.
package slotmap_pkg;
    localparam int FIELD_W    = 12;                 // page field width
    localparam int PAGE_SHIFT = 12;                 // 4 KiB pages
    localparam int SYS_AW     = FIELD_W + PAGE_SHIFT;
    localparam int IO_AW      = 16;
    localparam int SLOT_W     = 2;                  // index bits [7:6]
    localparam int REG_W      = 6;                  // index bits [5:0]
    localparam int REG_N      = 1 << REG_W;

    localparam logic [REG_W-1:0] REG_WIN_EN  = 6'h06;
    localparam logic [REG_W-1:0] REG_IO_CTL  = 6'h07;
    localparam int               IO_BASE     = 8;
    localparam int               IO_STRIDE   = 4;
    localparam int               MEM_BASE    = 16;
    localparam int               MEM_STRIDE  = 8;
    localparam int               IO_EN_BIT0  = 6;

    typedef struct packed {
        logic               en;
        logic               wide;
        logic               attr;
        logic [FIELD_W-1:0] start;
        logic [FIELD_W-1:0] stop;
        logic [FIELD_W-1:0] offs;
    } mem_win_t;

    typedef struct packed {
        logic             en;
        logic             wide;
        logic [IO_AW-1:0] lo;
        logic [IO_AW-1:0] hi;
    } io_win_t;

    // True for register numbers that hold storage in a slot.
    function automatic logic reg_is_impl(input logic [REG_W-1:0] r,
                                         input int n_mem, input int n_io);
        int v;
        v = int'(r);
        if (v == int'(REG_WIN_EN) || v == int'(REG_IO_CTL)) return 1'b1;
        if (v >= IO_BASE && v < IO_BASE + IO_STRIDE * n_io) return 1'b1;
        if (v >= MEM_BASE && v < MEM_BASE + MEM_STRIDE * n_mem && (v % MEM_STRIDE) < 6)
            return 1'b1;
        return 1'b0;
    endfunction
endpackage

// File: rtl/slotmap_slot_regs.sv
// Module: register file of one slot. Stores the bytes of implemented
// registers only, serves byte reads, and unpacks window fields.
// Assumes NUM_MEM_WIN <= 5 and NUM_IO_WIN <= 2 so the map fits 64 bytes.
module slotmap_slot_regs
    import slotmap_pkg::*;
#(
    parameter int NUM_MEM_WIN = 5,
    parameter int NUM_IO_WIN  = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [REG_W-1:0]            reg_idx,
    input  logic [7:0]                  wdata,
    output logic [7:0]                  rdata,
    output mem_win_t [NUM_MEM_WIN-1:0]  mem_win,
    output io_win_t  [NUM_IO_WIN-1:0]   io_win
);
    logic [7:0] regs_q [REG_N];
    logic       idx_impl;

    assign idx_impl = reg_is_impl(reg_idx, NUM_MEM_WIN, NUM_IO_WIN);

    // Byte storage: cleared by reset, written only at implemented indexes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < REG_N; i++) regs_q[i] <= '0;
        end else if (wr_en && idx_impl) begin
            regs_q[reg_idx] <= wdata;
        end
    end

    // Read path: unwritten (unimplemented) bytes stay zero.
    assign rdata = regs_q[reg_idx];

    // Memory window field unpacking, one block per window.
    for (genvar w = 0; w < NUM_MEM_WIN; w++) begin : g_mem
        localparam int B = MEM_BASE + MEM_STRIDE * w;
        assign mem_win[w].start = {regs_q[B+1][3:0], regs_q[B]};
        assign mem_win[w].stop  = {regs_q[B+3][3:0], regs_q[B+2]};
        assign mem_win[w].offs  = {regs_q[B+5][3:0], regs_q[B+4]};
        assign mem_win[w].wide  = regs_q[B+1][7];
        assign mem_win[w].attr  = regs_q[B+5][6];
        assign mem_win[w].en    = regs_q[REG_WIN_EN][w];
    end

    // I/O window field unpacking, one block per window.
    for (genvar w = 0; w < NUM_IO_WIN; w++) begin : g_io
        localparam int B = IO_BASE + IO_STRIDE * w;
        assign io_win[w].lo   = {regs_q[B+1], regs_q[B]};
        assign io_win[w].hi   = {regs_q[B+3], regs_q[B+2]};
        assign io_win[w].en   = regs_q[REG_WIN_EN][IO_EN_BIT0 + w];
        assign io_win[w].wide = regs_q[REG_IO_CTL][w];
    end

    // R2: an index without storage never returns a nonzero byte.
    p_unimpl_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !idx_impl |-> rdata == 8'h00);
endmodule

// File: rtl/slotmap_mem_decode.sv
// Module: memory lookup across all slots and windows. Compares the page
// against every enabled window, picks the lowest slot/window, and adds
// that window's offset once after selection. Purely combinational; the
// clock and reset feed only the assertions.
module slotmap_mem_decode
    import slotmap_pkg::*;
#(
    parameter int NUM_SLOTS   = 2,
    parameter int NUM_MEM_WIN = 5,
    parameter int WIN_W       = 3
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  mem_win_t [NUM_SLOTS*NUM_MEM_WIN-1:0]  wins,
    input  logic [SYS_AW-1:0]                     sys_addr,
    output logic                                  hit,
    output logic [SLOT_W-1:0]                     slot,
    output logic [WIN_W-1:0]                      win,
    output logic [SYS_AW-1:0]                     card_addr,
    output logic                                  attr,
    output logic                                  wide
);
    localparam int N = NUM_SLOTS * NUM_MEM_WIN;

    logic [FIELD_W-1:0] page;
    logic [FIELD_W-1:0] sel_offs;
    logic [N-1:0]       match;
    logic [N-1:0]       en_vec;

    assign page = sys_addr[SYS_AW-1:PAGE_SHIFT];

    // Per-window inclusive range compare.
    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign en_vec[i] = wins[i].en;
        assign match[i]  = wins[i].en && (page >= wins[i].start) && (page <= wins[i].stop);
    end

    // Priority pick: scanning downward lets the lowest index win.
    always_comb begin
        hit      = 1'b0;
        slot     = '0;
        win      = '0;
        sel_offs = '0;
        attr     = 1'b0;
        wide     = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit      = 1'b1;
                slot     = SLOT_W'(i / NUM_MEM_WIN);
                win      = WIN_W'(i % NUM_MEM_WIN);
                sel_offs = wins[i].offs;
                attr     = wins[i].attr;
                wide     = wins[i].wide;
            end
        end
    end

    // Translation: a single wrap-around adder on the selected offset.
    assign card_addr = {page + sel_offs, sys_addr[PAGE_SHIFT-1:0]};

    // R4: with every window disabled nothing may hit.
    p_all_off_no_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (en_vec == '0) |-> !hit);
    // R5: the byte offset within the page passes through unchanged.
    p_low_bits_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> card_addr[PAGE_SHIFT-1:0] == sys_addr[PAGE_SHIFT-1:0]);
endmodule

// File: rtl/slotmap_io_decode.sv
// Module: I/O port lookup across all slots and I/O windows, no address
// translation. Lowest slot and window win on overlap. Combinational;
// clock and reset feed only the assertions.
module slotmap_io_decode
    import slotmap_pkg::*;
#(
    parameter int NUM_SLOTS  = 2,
    parameter int NUM_IO_WIN = 2,
    parameter int IO_WIN_W   = 1
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  io_win_t [NUM_SLOTS*NUM_IO_WIN-1:0]  wins,
    input  logic [IO_AW-1:0]                    port_addr,
    output logic                                hit,
    output logic [SLOT_W-1:0]                   slot,
    output logic [IO_WIN_W-1:0]                 win,
    output logic                                wide
);
    localparam int N = NUM_SLOTS * NUM_IO_WIN;

    logic [N-1:0] match;
    logic [N-1:0] en_vec;

    // Per-window inclusive range compare.
    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign en_vec[i] = wins[i].en;
        assign match[i]  = wins[i].en && (port_addr >= wins[i].lo) && (port_addr <= wins[i].hi);
    end

    // Priority pick, lowest index wins.
    always_comb begin
        hit  = 1'b0;
        slot = '0;
        win  = '0;
        wide = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit  = 1'b1;
                slot = SLOT_W'(i / NUM_IO_WIN);
                win  = IO_WIN_W'(i % NUM_IO_WIN);
                wide = wins[i].wide;
            end
        end
    end

    // R8: disabled I/O windows never decode.
    p_io_all_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (en_vec == '0) |-> !hit);
endmodule

// File: rtl/slot_window_map.sv
// Module: top of the slot window mapper. Holds the index register, routes
// data-port accesses to the addressed slot, and joins the memory and I/O
// decoders. Assumes NUM_SLOTS <= 4 (two index bits select the slot).
module slot_window_map
    import slotmap_pkg::*;
#(
    parameter int NUM_SLOTS   = 2,
    parameter int NUM_MEM_WIN = 5,
    parameter int NUM_IO_WIN  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_sel_data,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    input  logic [23:0]       mem_addr,
    output logic              mem_hit,
    output logic [1:0]        mem_slot,
    output logic [2:0]        mem_win,
    output logic [23:0]       mem_card_addr,
    output logic              mem_attr,
    output logic              mem_wide,
    input  logic [15:0]       io_addr,
    output logic              io_hit,
    output logic [1:0]        io_slot,
    output logic [0:0]        io_win,
    output logic              io_wide
);
    localparam int WIN_W    = $clog2(NUM_MEM_WIN);
    localparam int IO_WIN_W = (NUM_IO_WIN > 1) ? $clog2(NUM_IO_WIN) : 1;

    logic [7:0]              index_q;
    logic [SLOT_W-1:0]       slot_sel;
    logic [REG_W-1:0]        reg_sel;
    logic [7:0]              slot_rd [NUM_SLOTS];
    logic [7:0]              data_rd;
    mem_win_t [NUM_SLOTS*NUM_MEM_WIN-1:0] all_mem;
    io_win_t  [NUM_SLOTS*NUM_IO_WIN-1:0]  all_io;

    assign slot_sel = index_q[7:6];
    assign reg_sel  = index_q[REG_W-1:0];

    // Index register: loaded only by index-port writes.
    always_ff @(posedge clk) begin
        if (!rst_n)                        index_q <= '0;
        else if (host_wr && !host_sel_data) index_q <= host_wdata;
    end

    // One register file per slot, written when the index selects it.
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        slotmap_slot_regs #(
            .NUM_MEM_WIN (NUM_MEM_WIN),
            .NUM_IO_WIN  (NUM_IO_WIN)
        ) u_regs (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (host_wr && host_sel_data && (slot_sel == SLOT_W'(s))),
            .reg_idx (reg_sel),
            .wdata   (host_wdata),
            .rdata   (slot_rd[s]),
            .mem_win (all_mem[s*NUM_MEM_WIN +: NUM_MEM_WIN]),
            .io_win  (all_io[s*NUM_IO_WIN +: NUM_IO_WIN])
        );
    end

    // Data-port read mux; absent slots read zero.
    always_comb begin
        data_rd = '0;
        for (int s = 0; s < NUM_SLOTS; s++)
            if (slot_sel == SLOT_W'(s)) data_rd = slot_rd[s];
    end

    // Host read: index port or selected register byte.
    assign host_rdata = host_sel_data ? data_rd : index_q;

    slotmap_mem_decode #(
        .NUM_SLOTS   (NUM_SLOTS),
        .NUM_MEM_WIN (NUM_MEM_WIN),
        .WIN_W       (WIN_W)
    ) u_mem (
        .clk       (clk),
        .rst_n     (rst_n),
        .wins      (all_mem),
        .sys_addr  (mem_addr),
        .hit       (mem_hit),
        .slot      (mem_slot),
        .win       (mem_win),
        .card_addr (mem_card_addr),
        .attr      (mem_attr),
        .wide      (mem_wide)
    );

    slotmap_io_decode #(
        .NUM_SLOTS  (NUM_SLOTS),
        .NUM_IO_WIN (NUM_IO_WIN),
        .IO_WIN_W   (IO_WIN_W)
    ) u_io (
        .clk       (clk),
        .rst_n     (rst_n),
        .wins      (all_io),
        .port_addr (io_addr),
        .hit       (io_hit),
        .slot      (io_slot),
        .win       (io_win),
        .wide      (io_wide)
    );

    // R1: a data-port write leaves the index untouched.
    p_index_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_sel_data) |=> $stable(index_q));
    // R3: leaving reset, no lookup reports a hit.
    p_reset_no_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!mem_hit && !io_hit));
    // R9: out-of-range slot numbers read zero on the data port.
    p_bad_slot_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (host_sel_data && int'(slot_sel) >= NUM_SLOTS) |-> host_rdata == 8'h00);
endmodule

// File: tb/slot_window_map_tb.sv
module slot_window_map_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic        host_sel_data = 1'b0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic [23:0] mem_addr = '0;
    logic        mem_hit;
    logic [1:0]  mem_slot;
    logic [2:0]  mem_win;
    logic [23:0] mem_card_addr;
    logic        mem_attr, mem_wide;
    logic [15:0] io_addr = '0;
    logic        io_hit;
    logic [1:0]  io_slot;
    logic [0:0]  io_win;
    logic        io_wide;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 0;
    logic [7:0] m_regs [4][64];

    always #(CLK_PERIOD/2) clk = ~clk;

    slot_window_map u_dut (.*);

    function automatic bit m_impl(int r);
        if (r == 6 || r == 7) return 1;
        if (r >= 8 && r <= 15) return 1;
        if (r >= 16 && r <= 55 && (r % 8) <= 5) return 1;
        return 0;
    endfunction

    function automatic logic [11:0] fld(int s, int b);
        return {m_regs[s][b+1][3:0], m_regs[s][b]};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_port(bit sel, logic [7:0] v);
        @(negedge clk);
        host_sel_data = sel; host_wr = 1'b1; host_wdata = v;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic write_reg(int s, int r, logic [7:0] v);
        wr_port(1'b0, 8'((s << 6) | r));
        wr_port(1'b1, v);
        if (s < NS && m_impl(r)) m_regs[s][r] = v;
    endtask

    task automatic read_data(string req, int s, int r);
        logic [7:0] exp;
        wr_port(1'b0, 8'((s << 6) | r));
        host_sel_data = 1'b1;
        #1;
        exp = (s < NS && m_impl(r)) ? m_regs[s][r] : 8'h00;
        chk(req, {24'h0, host_rdata}, {24'h0, exp});
    endtask

    // Model of the memory lookup: first hit in slot/window order.
    task automatic check_mem(string req, logic [23:0] a);
        bit eh = 0; int es = 0, ew = 0; logic [11:0] pg, offs = 0; bit ea = 0, ewd = 0;
        pg = a[23:12];
        for (int s = 0; s < NS && !eh; s++)
            for (int w = 0; w < 5 && !eh; w++) begin
                int b = 16 + 8 * w;
                if (m_regs[s][6][w] && pg >= fld(s, b) && pg <= fld(s, b + 2)) begin
                    eh = 1; es = s; ew = w; offs = fld(s, b + 4);
                    ea = m_regs[s][b+5][6]; ewd = m_regs[s][b+1][7];
                end
            end
        mem_addr = a;
        #1;
        if (!eh) chk(req, {31'h0, mem_hit}, 32'h0);
        else begin
            logic [11:0] cp;
            cp = pg + offs;
            chk(req, {mem_hit, 1'b0, mem_slot, 1'b0, mem_win, mem_attr, mem_wide, mem_card_addr},
                {1'b1, 1'b0, 2'(es), 1'b0, 3'(ew), ea, ewd, cp, a[11:0]});
        end
    endtask

    task automatic check_io(string req, logic [15:0] a);
        bit eh = 0; int es = 0, ew = 0; bit ewd = 0;
        for (int s = 0; s < NS && !eh; s++)
            for (int w = 0; w < 2 && !eh; w++) begin
                int b = 8 + 4 * w;
                logic [15:0] lo, hi;
                lo = {m_regs[s][b+1], m_regs[s][b]};
                hi = {m_regs[s][b+3], m_regs[s][b+2]};
                if (m_regs[s][6][6+w] && a >= lo && a <= hi) begin
                    eh = 1; es = s; ew = w; ewd = m_regs[s][7][w];
                end
            end
        io_addr = a;
        #1;
        if (!eh) chk(req, {31'h0, io_hit}, 32'h0);
        else chk(req, {27'h0, io_hit, io_slot, io_win, io_wide}, {27'h0, 1'b1, 2'(es), 1'(ew), ewd});
    endtask

    task automatic set_mem(int s, int w, logic [11:0] st, logic [11:0] sp, logic [11:0] of,
                           logic [3:0] ctl_st, logic [3:0] ctl_of);
        int b = 16 + 8 * w;
        write_reg(s, b, st[7:0]);     write_reg(s, b + 1, {ctl_st, st[11:8]});
        write_reg(s, b + 2, sp[7:0]); write_reg(s, b + 3, {4'h0, sp[11:8]});
        write_reg(s, b + 4, of[7:0]); write_reg(s, b + 5, {ctl_of, of[11:8]});
    endtask

    initial begin
        int dummy;
        for (int s = 0; s < 4; s++) for (int r = 0; r < 64; r++) m_regs[s][r] = 8'h00;
        dummy = $urandom(32'd4242);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R3: reset state
        host_sel_data = 1'b0; #1;
        chk("R3 index after reset", {24'h0, host_rdata}, 32'h0);
        check_mem("R3 no mem hit after reset", 24'h000123);
        check_mem("R3 no mem hit after reset", 24'hFFFFFF);
        check_io("R3 no io hit after reset", 16'h0000);
        read_data("R3 register zero after reset", 0, 6);

        // R1: index persistence across data accesses
        wr_port(1'b0, 8'h12);
        host_sel_data = 1'b0; #1;
        chk("R1 index readback", {24'h0, host_rdata}, 32'h12);
        wr_port(1'b1, 8'hAA);
        wr_port(1'b1, 8'h55);
        m_regs[0][8'h12] = 8'h55;
        host_sel_data = 1'b1; #1;
        chk("R1 second data write same register", {24'h0, host_rdata}, 32'h55);
        host_sel_data = 1'b0; #1;
        chk("R1 index unchanged by data writes", {24'h0, host_rdata}, 32'h12);

        // R2: unimplemented indexes
        write_reg(0, 8'h16, 8'hFF);
        read_data("R2 unimplemented reads zero", 0, 8'h16);
        write_reg(1, 8'h3F, 8'hA5);
        read_data("R2 unimplemented reads zero", 1, 8'h3F);
        write_reg(0, 8'h07, 8'h3C);
        read_data("R2 implemented readback", 0, 8'h07);

        // R9: slot bases and absent slots
        write_reg(1, 8'h10, 8'h77);
        read_data("R9 slot1 register", 1, 8'h10);
        read_data("R9 slot0 not aliased", 0, 8'h10);
        write_reg(2, 8'h10, 8'h99);
        read_data("R9 absent slot reads zero", 2, 8'h10);
        read_data("R9 absent slot write no effect on slot0", 0, 8'h10);

        // R4/R5: boundaries and wraparound offset, window 0 of slot 0
        set_mem(0, 0, 12'h100, 12'h1FF, 12'hF80, 4'h0, 4'h0);
        check_mem("R4 disabled window no hit", 24'h100000);
        write_reg(0, 6, 8'h01);
        check_mem("R4 start page inclusive", 24'h100ABC);
        check_mem("R4 stop page inclusive", 24'h1FFFFF);
        check_mem("R4 page below start", 24'h0FFFFF);
        check_mem("R4 page above stop", 24'h200000);
        check_mem("R5 offset wraps modulo 4096 pages", 24'h1A0321);

        // R6/R10: control bits in high bytes
        set_mem(0, 2, 12'h400, 12'h40F, 12'h010, 4'h8, 4'h4);
        write_reg(0, 6, 8'h05);
        check_mem("R6 attribute and width flags", 24'h405010);
        set_mem(0, 2, 12'h400, 12'h40F, 12'h010, 4'hF, 4'hB);
        check_mem("R10 control nibbles do not alter field", 24'h40F777);
        check_mem("R10 control nibbles do not widen range", 24'hF0F000);

        // R7: overlap priority
        set_mem(1, 0, 12'h800, 12'h8FF, 12'h001, 4'h0, 4'h0);
        write_reg(1, 6, 8'h01);
        check_mem("R7 only slot1 hits", 24'h850000);
        set_mem(0, 3, 12'h840, 12'h860, 12'h002, 4'h0, 4'h0);
        write_reg(0, 6, 8'h0D);
        check_mem("R7 lower slot wins", 24'h850000);
        set_mem(0, 1, 12'h850, 12'h850, 12'h003, 4'h0, 4'h0);
        write_reg(0, 6, 8'h0F);
        check_mem("R7 lower window wins", 24'h850000);

        // R8: I/O windows
        write_reg(0, 8, 8'h00); write_reg(0, 9, 8'h03);
        write_reg(0, 10, 8'h1F); write_reg(0, 11, 8'h03);
        check_io("R8 disabled io window", 16'h0300);
        write_reg(0, 6, 8'h4F);
        write_reg(0, 7, 8'h01);
        check_io("R8 io start inclusive", 16'h0300);
        check_io("R8 io stop inclusive", 16'h031F);
        check_io("R8 io above stop", 16'h0320);
        write_reg(1, 12, 8'h10); write_reg(1, 13, 8'h03);
        write_reg(1, 14, 8'hFF); write_reg(1, 15, 8'h03);
        write_reg(1, 6, 8'h81);
        check_io("R8 io overlap lower slot wins", 16'h0310);
        check_io("R8 io slot1 window1", 16'h0350);

        // Random mix: register writes, readbacks and lookups (R2 R4 R5 R6 R7 R8)
        for (int it = 0; it < 300; it++) begin
            int s = ($urandom % 8 == 0) ? 2 + ($urandom % 2) : $urandom % NS;
            int r = $urandom % 64;
            logic [7:0] v = 8'($urandom);
            if (r == 6) v = v | 8'h01;
            write_reg(s, r, v);
            if (it % 4 == 0) read_data("R2 random readback", s, $urandom % 64);
            for (int k = 0; k < 3; k++) begin
                int ss = $urandom % NS;
                int ww = $urandom % 5;
                logic [11:0] pg = fld(ss, 16 + 8 * ww) + 12'($urandom % 3) - 12'd1;
                check_mem("R4 random lookup", {pg, 12'($urandom)});
                check_mem("R5 random lookup", 24'($urandom));
            end
            check_io("R8 random io lookup",
                     {m_regs[$urandom % NS][9], 8'($urandom)});
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule